// File: doc/BRIEF.md
# Round-Robin Channel Trigger Unit

This block merges the trigger pulses of nine lighting-modulator channels into one module-level trigger. Each channel's pulse counts only when that channel's enable bit is set. In OR mode any enabled pulse fires the module trigger. In round-robin mode only the channel that currently holds the turn can fire it, and each firing hands the turn to the next enabled channel. The module trigger can be held back by a quarter or half of a bit time. The index of the channel that caused the latest module trigger is reported. Independently of the arbitration, each enabled channel pulse is copied onto one of two trigger lines, chosen by that channel's line-select bit.

The delay is built as a two-state machine. In `ST_READY` the unit accepts a request. A request with zero wait fires at once (transition T_PASS). A request with nonzero wait loads a countdown and moves to `ST_DEFER` (transition T_DEFER). In `ST_DEFER` the countdown decrements (T_COUNT). When it reaches zero the pending trigger is released and the machine returns to `ST_READY` (T_RELEASE). The bit time is `CLK_PER_BIT` module clocks (default 4), so a quarter bit time is 1 clock and a half bit time is 2 clocks.

Top module: `rr_trigger_unit`

## Requirements
- R1: With `rr_mode`=0, a cycle in which any enabled channel pulses gives `mod_trig`=1. `last_src` becomes the lowest index among the enabled pulsing channels.
- R2: With `rr_mode`=1, only a pulse on the channel holding the turn fires `mod_trig`. Pulses on other enabled channels fire nothing.
- R3: The turn starts at channel 0 after reset. Each round-robin firing moves the turn to the next enabled channel, searching upward and wrapping from 8 to 0. If the channel holding the turn is disabled while another channel is enabled, the turn moves to the next enabled channel on the following clock. With no channel enabled, the turn holds.
- R4: `dly_code` sets the delay. 2'b00 and 2'b11 make `mod_trig` rise one cycle after the pulse cycle. 2'b01 makes it rise 1+CLK_PER_BIT/4 cycles after (2 by default). 2'b10 makes it rise 1+CLK_PER_BIT/2 cycles after (3 by default).
- R5: With `fast_mode`=1, every `dly_code` value acts as no delay (latency 1).
- R6: While a delayed trigger is pending (`ST_DEFER`), further channel pulses are ignored by the arbitration and by the delay.
- R7: `last_src` (4 bits) changes only in the cycle in which `mod_trig` is 1. Otherwise it holds its value. It always stays below 9.
- R8: One cycle after enabled channel i pulses, trigger line `out_sel[i]` pulses: select bit 0 drives `trig_line[0]` and select bit 1 drives `trig_line[1]`. This happens in both modes and whatever the delay.
- R9: A pulse on a disabled channel produces no `mod_trig`, no line pulse and no change of `last_src`.
- R10: During reset, `mod_trig`, `trig_line` and `last_src` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_trig | input | 9 | Per-channel single-cycle trigger pulses |
| trig_en | input | 9 | Per-channel trigger enable |
| out_sel | input | 9 | Per-channel trigger line select (0: line 0, 1: line 1) |
| rr_mode | input | 1 | 0: OR arbitration, 1: round-robin arbitration |
| dly_code | input | 2 | Module trigger delay code |
| fast_mode | input | 1 | Fast bit-clock mode; forces zero delay |
| mod_trig | output | 1 | Module trigger pulse |
| trig_line | output | 2 | Routed trigger line pulses |
| last_src | output | 4 | Channel index behind the latest module trigger |

## Verification
Both trigger lines follow a pulse after one clock edge. `mod_trig` follows after one, two or three edges, depending on `dly_code` and `fast_mode`. The bench drives each pulse on a falling edge and holds it for one cycle. It then checks `mod_trig` at each of the next three falling edges, expecting it high only at the computed latency and low at the others. It reads `last_src` at that same falling edge. In round-robin sweeps the bench tracks the turn from R3 alone, using the known enable mask and the next-enabled rule.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_DEFER = 1'b1
    } rrt_state_e;

    typedef enum logic [1:0] {
        DLY_NONE     = 2'b00,
        DLY_QUARTER  = 2'b01,
        DLY_HALF     = 2'b10,
        DLY_NONE_ALT = 2'b11
    } rrt_dly_e;
endpackage

// File: rtl/rrt_arbiter.sv
module rrt_arbiter #(
    parameter int NCH   = 9,
    parameter int IDX_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   qual,
    input  logic [NCH-1:0]   trig_en,
    input  logic             rr_mode,
    input  logic             accept,
    output logic             fire_req,
    output logic [IDX_W-1:0] fire_src
);
    logic [IDX_W-1:0] turn;
    logic [IDX_W-1:0] turn_nx;
    logic             nx_found;
    logic [IDX_W-1:0] low_idx;
    logic             advance;

    // next enabled channel after the current turn, ascending with wrap
    always_comb begin
        turn_nx  = turn;
        nx_found = 1'b0;
        for (int k = 1; k <= NCH; k++) begin
            int cand;
            cand = int'(turn) + k;
            if (cand >= NCH) cand = cand - NCH;
            if (!nx_found && trig_en[cand]) begin
                turn_nx  = IDX_W'(cand);
                nx_found = 1'b1;
            end
        end
    end

    // lowest-index qualified channel for OR mode
    always_comb begin
        low_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (qual[i]) low_idx = IDX_W'(i);
        end
    end

    assign fire_req = rr_mode ? qual[turn] : (|qual);
    assign fire_src = rr_mode ? turn : low_idx;
    assign advance  = nx_found && ((rr_mode && qual[turn] && accept) || !trig_en[turn]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn <= '0;
        end else if (advance) begin
            turn <= turn_nx;
        end
    end
endmodule

// File: rtl/rrt_delay_fsm.sv
module rrt_delay_fsm
    import rrt_pkg::*;
#(
    parameter int CLK_PER_BIT = 4,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_req,
    input  logic [IDX_W-1:0] fire_src,
    input  logic [1:0]       dly_code,
    input  logic             fast_mode,
    output logic             ready,
    output logic             mod_trig,
    output logic [IDX_W-1:0] last_src
);
    localparam int QTR   = CLK_PER_BIT / 4;
    localparam int HALF  = CLK_PER_BIT / 2;
    localparam int CNT_W = $clog2(HALF + 1);

    rrt_state_e       state, state_nx;
    logic [CNT_W-1:0] wait_len;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] pend_src;

    always_comb begin
        wait_len = '0;
        if (!fast_mode) begin
            unique case (rrt_dly_e'(dly_code))
                DLY_QUARTER: wait_len = CNT_W'(QTR);
                DLY_HALF:    wait_len = CNT_W'(HALF);
                default:     wait_len = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    // transitions: T_PASS, T_DEFER, T_COUNT, T_RELEASE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: if (fire_req && (wait_len != '0)) state_nx = ST_DEFER;
            ST_DEFER: if (cnt == '0) state_nx = ST_READY;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_trig <= 1'b0;
            last_src <= '0;
            cnt      <= '0;
            pend_src <= '0;
        end else begin
            mod_trig <= 1'b0;
            unique case (state)
                ST_READY: begin
                    if (fire_req) begin
                        if (wait_len == '0) begin
                            mod_trig <= 1'b1;
                            last_src <= fire_src;
                        end else begin
                            cnt      <= wait_len - CNT_W'(1);
                            pend_src <= fire_src;
                        end
                    end
                end
                ST_DEFER: begin
                    if (cnt == '0) begin
                        mod_trig <= 1'b1;
                        last_src <= pend_src;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign ready = (state == ST_READY);
endmodule

// File: rtl/rrt_router.sv
module rrt_router #(
    parameter int NCH   = 9,
    parameter int NLINE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   qual,
    input  logic [NCH-1:0]   out_sel,
    output logic [NLINE-1:0] trig_line
);
    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [NCH-1:0] hit;
        assign hit = (g == 0) ? (qual & ~out_sel) : (qual & out_sel);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig_line[g] <= 1'b0;
            else        trig_line[g] <= |hit;
        end
    end
endmodule

// File: rtl/rr_trigger_unit.sv
module rr_trigger_unit #(
    parameter int NCH         = 9,
    parameter int CLK_PER_BIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         ch_trig,
    input  logic [NCH-1:0]         trig_en,
    input  logic [NCH-1:0]         out_sel,
    input  logic                   rr_mode,
    input  logic [1:0]             dly_code,
    input  logic                   fast_mode,
    output logic                   mod_trig,
    output logic [1:0]             trig_line,
    output logic [$clog2(NCH)-1:0] last_src
);
    localparam int IDX_W = $clog2(NCH);

    logic [NCH-1:0]   qual;
    logic             fire_req;
    logic [IDX_W-1:0] fire_src;
    logic             ready;

    assign qual = ch_trig & trig_en;

    rrt_arbiter #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .trig_en  (trig_en),
        .rr_mode  (rr_mode),
        .accept   (ready),
        .fire_req (fire_req),
        .fire_src (fire_src)
    );

    rrt_delay_fsm #(.CLK_PER_BIT(CLK_PER_BIT), .IDX_W(IDX_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_req  (fire_req && ready),
        .fire_src  (fire_src),
        .dly_code  (dly_code),
        .fast_mode (fast_mode),
        .ready     (ready),
        .mod_trig  (mod_trig),
        .last_src  (last_src)
    );

    rrt_router #(.NCH(NCH), .NLINE(2)) u_rte (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (qual),
        .out_sel   (out_sel),
        .trig_line (trig_line)
    );
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
    parameter int NCH = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         ch_trig,
    input logic [NCH-1:0]         trig_en,
    input logic [NCH-1:0]         out_sel,
    input logic                   mod_trig,
    input logic [1:0]             trig_line,
    input logic [$clog2(NCH)-1:0] last_src
);
    logic [NCH-1:0] q;
    logic [1:0]     seen;

    assign q = ch_trig & trig_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R9: three quiet cycles of enabled pulses leave no module trigger
    a_r9_quiet_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen == 2'd3) && $past(q == '0, 1) && $past(q == '0, 2) && $past(q == '0, 3))
        |-> !mod_trig);

    // R8: lines follow the enabled pulses one cycle later
    a_r8_line_routing: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0) |-> (trig_line == {$past(|(q & out_sel)), $past(|(q & ~out_sel))}));

    // R7: source index holds between module triggers
    a_r7_src_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen != 2'd0) && !mod_trig) |-> $stable(last_src));

    // R7: source index stays within the channel count
    a_r7_src_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(last_src) < NCH);
endmodule

bind rr_trigger_unit rrt_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_trig   (ch_trig),
    .trig_en   (trig_en),
    .out_sel   (out_sel),
    .mod_trig  (mod_trig),
    .trig_line (trig_line),
    .last_src  (last_src)
);

// File: tb/sim_rr_trigger_unit.sv
module sim_rr_trigger_unit;
    localparam int NCH = 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ch_trig = '0;
    logic [NCH-1:0] trig_en = '0;
    logic [NCH-1:0] out_sel = '0;
    logic           rr_mode = 1'b0;
    logic [1:0]     dly_code = 2'b00;
    logic           fast_mode = 1'b0;
    logic           mod_trig;
    logic [1:0]     trig_line;
    logic [3:0]     last_src;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rr_trigger_unit #(.NCH(NCH), .CLK_PER_BIT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_trig(ch_trig), .trig_en(trig_en),
        .out_sel(out_sel), .rr_mode(rr_mode), .dly_code(dly_code),
        .fast_mode(fast_mode), .mod_trig(mod_trig), .trig_line(trig_line),
        .last_src(last_src)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [1:0] c, input logic f);
        if (f) return 1;
        if (c == 2'b01) return 2;
        if (c == 2'b10) return 3;
        return 1;
    endfunction

    function automatic int lowest(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int next_en(input int p, input logic [NCH-1:0] en);
        for (int k = 1; k <= NCH; k++) if (en[(p + k) % NCH]) return (p + k) % NCH;
        return p;
    endfunction

    // one-cycle pulse, then check lines (R8) and trigger timing/source
    task automatic pulse(input logic [NCH-1:0] m, input bit ef, input int es, input string req);
        int lat;
        int prev;
        lat  = exp_lat(dly_code, fast_mode);
        prev = int'(last_src);
        @(negedge clk) ch_trig = m;
        @(negedge clk) ch_trig = '0;
        chk({req, " R8 line0"}, int'(trig_line[0]), int'(|(m & trig_en & ~out_sel)));
        chk({req, " R8 line1"}, int'(trig_line[1]), int'(|(m & trig_en & out_sel)));
        for (int c = 1; c <= 3; c++) begin
            if (c > 1) @(negedge clk);
            chk({req, " trig"}, int'(mod_trig), int'(ef && (c == lat)));
            if (ef && (c == lat)) chk({req, " src"}, int'(last_src), es);
        end
        if (!ef) chk({req, " R7 src hold"}, int'(last_src), prev);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic home_turn();
        @(negedge clk) trig_en = 9'h001;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [NCH-1:0] m;
        logic [NCH-1:0] en;
        int p;

        repeat (3) @(negedge clk);
        chk("R10 reset trig", int'(mod_trig), 0);
        chk("R10 reset lines", int'(trig_line), 0);
        chk("R10 reset src", int'(last_src), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9: every single channel, enabled or not, both lines
        for (int i = 0; i < NCH; i++) begin
            for (int e = 0; e < 2; e++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [NCH-1:0] one;
                    one = '0;
                    one[i] = 1'b1;
                    trig_en = (e != 0) ? one : ~one;
                    out_sel = (s != 0) ? one : '0;
                    pulse(one, e != 0, i, (e != 0) ? "R1 single" : "R9 disabled");
                end
            end
        end

        // R1: multi-channel patterns, lowest enabled index wins
        for (int j = 0; j < 24; j++) begin
            m       = NCH'((j * 173 + 29) % 512);
            trig_en = NCH'((j * 91 + 300) % 512);
            out_sel = NCH'((j * 57) % 512);
            pulse(m, |(m & trig_en), lowest(m & trig_en), "R1 multi");
        end

        // R4 / R5: delay code sweep in both bit-clock modes
        trig_en = '1;
        out_sel = '0;
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 4; c++) begin
                dly_code  = 2'(c);
                fast_mode = (f != 0);
                pulse(9'h008, 1'b1, 3, (f != 0) ? "R5 fast" : "R4 delay");
            end
        end
        fast_mode = 1'b0;

        // R6: pulse during a pending half-bit delay is dropped
        dly_code = 2'b10;
        @(negedge clk) ch_trig = 9'h001;
        @(negedge clk) ch_trig = 9'h020;
        @(negedge clk) ch_trig = '0;
        chk("R6 before release", int'(mod_trig), 0);
        @(negedge clk);
        chk("R6 release", int'(mod_trig), 1);
        chk("R6 release src", int'(last_src), 0);
        @(negedge clk);
        chk("R6 no second", int'(mod_trig), 0);
        @(negedge clk);
        chk("R6 no second late", int'(mod_trig), 0);
        chk("R6 src kept", int'(last_src), 0);
        dly_code = 2'b00;
        repeat (2) @(negedge clk);

        // R2 / R3: round-robin sweeps over several enable masks
        rr_mode = 1'b1;
        for (int j = 0; j < 6; j++) begin
            en = NCH'((j * 211 + 77) % 512) | 9'h001;
            home_turn();
            trig_en = en;
            out_sel = NCH'((j * 99 + 5) % 512);
            p = 0;
            if (next_en(p, en) != p) begin
                m = '0;
                m[next_en(p, en)] = 1'b1;
                pulse(m, 1'b0, 0, "R2 not turn");
            end
            for (int k = 0; k < 12; k++) begin
                pulse('1, 1'b1, p, "R3 rotate");
                p = next_en(p, en);
            end
        end

        // R3: disabled turn holder skips ahead; turn holds with none enabled
        home_turn();
        trig_en = 9'h010;
        repeat (2) @(negedge clk);
        pulse(9'h010, 1'b1, 4, "R3 skip");
        trig_en = '0;
        repeat (3) @(negedge clk);
        pulse('1, 1'b0, 0, "R9 none enabled");
        trig_en = 9'h090;
        repeat (2) @(negedge clk);
        pulse(9'h080, 1'b0, 0, "R2 hold not turn");
        pulse(9'h010, 1'b1, 4, "R3 hold");
        pulse(9'h080, 1'b1, 7, "R3 after hold");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule